// File: doc/BRIEF.md
# Write-Ordering Arbiter for Posted Writes and Snoop Write-Backs

This block sits between a processor's posted-write path and a single memory-bus write port. A snoop write-back path, carrying modified lines that a snoop has evicted, shares the same port. The block decides which write goes to memory next. Processor writes wait in a small FIFO. Each entry carries a sequence tag, which is the FIFO write pointer with one extra wrap bit. A single registered output stage holds the write that is currently on the bus.

An active-low configuration input selects the ordering policy. The block captures it on every clock edge while reset is high and keeps the value it latched on the last reset edge. After reset the input is a different functional signal, so the block ignores it. In strong ordering, a snoop write-back takes the current tail tag as its stamp. It is granted only when the FIFO head tag equals that stamp, which means every older posted write has already left. In weak ordering, a pending snoop write-back wins the bus port as soon as the port is free, ahead of any buffered writes.

A locked-cycle input forces strong ordering while it is high. The forcing continues after the input falls, until both the buffer and the output stage are empty. The block also drives a write-buffer-empty flag to the processor. In weak mode this flag is held high. In strong mode it is high only when nothing is buffered and nothing is on the bus.

Top module: `wr_order_arb`

## Requirements
- R1: The ordering mode is latched from `cfg_order_n` on each clock edge while `rst` is high. A 0 selects weak ordering and a 1 selects strong ordering.
- R2: After `rst` falls, changes on `cfg_order_n` have no effect. The latched mode persists until the next reset.
- R3: The posted-write FIFO holds DEPTH entries (default 4). `cpu_wr_ready` is 0 whenever it is full, and no write is accepted while it is full.
- R4: In strong mode, a snoop write-back reaches the bus only after every processor write accepted before the snoop request arrived.
- R5: In weak mode, a pending snoop write-back is placed on the bus at the first free slot, ahead of writes still held in the FIFO.
- R6: In weak mode, `wb_empty` is 1 on every cycle after the first clock edge following reset.
- R7: In strong mode, `wb_empty` is 1 exactly when the FIFO is empty and `mem_valid` is 0.
- R8: While `cpu_lock` is 1, and after it falls until the FIFO and the output stage are both empty, the block applies strong ordering even in weak mode.
- R9: Reset empties the FIFO and clears `mem_valid` and `wb_empty`. Writes accepted before the reset never reach the bus.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_data` and `mem_src` hold steady.
- R11: Processor writes reach the bus in the order they were accepted. `mem_src` is 0 for a processor write and 1 for a snoop write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_order_n | input | 1 | Ordering strap, sampled during reset (0 = weak) |
| cpu_lock | input | 1 | Locked read-modify-write in progress |
| cpu_wr_valid | input | 1 | Processor write request |
| cpu_wr_ready | output | 1 | FIFO can accept a write |
| cpu_wr_addr | input | AW | Processor write address |
| cpu_wr_data | input | DW | Processor write data |
| snp_valid | input | 1 | Snoop write-back request, held until accepted |
| snp_ready | output | 1 | Snoop write-back accepted this cycle |
| snp_addr | input | AW | Write-back line address |
| snp_data | input | DW | Write-back data |
| mem_valid | output | 1 | Bus write valid |
| mem_ready | input | 1 | Bus accepts the write |
| mem_addr | output | AW | Bus write address |
| mem_data | output | DW | Bus write data |
| mem_src | output | 1 | 0 = processor write, 1 = snoop write-back |
| wb_empty | output | 1 | Write-buffer-empty flag to the processor |

## Verification
The embedded assertions check the following on every cycle:
- the FIFO never overflows;
- the latched mode never changes outside reset;
- a stalled bus write stays frozen;
- `wb_empty` follows the mode-dependent rule;
- a stamped snoop in strong mode never passes an older buffered entry;
- in weak mode, a snoop is never held back from a free port.

Only the directed scenarios can show the complete drain order for a given mix of posted writes and snoops. They also show the effect of the lock holding strong ordering after it is released, and the discarding of buffered writes by a mid-stream reset.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic {
    SRC_CPU   = 1'b0,
    SRC_SNOOP = 1'b1
  } wo_src_e;
endpackage

// File: rtl/wo_mode_latch.sv
module wo_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic cfg_order_n,
  output logic weak_o
);
  // Mode is captured only while reset is high; afterwards the pin carries other traffic.
  always_ff @(posedge clk) begin
    if (rst) weak_o <= ~cfg_order_n;
  end

  // R2: the latched mode never moves outside reset
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(weak_o));
endmodule

// File: rtl/wo_post_fifo.sv
module wo_post_fifo #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int TW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty,
  output logic [TW-1:0] wr_tag,
  output logic [TW-1:0] rd_tag
);
  // Storage has no reset so it can map to distributed RAM; DEPTH must be a power of two.
  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wr_tag[PW-1:0]] <= push_addr;
      data_mem[wr_tag[PW-1:0]] <= push_data;
    end
  end

  // Pointers double as sequence tags: the extra MSB disambiguates wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_tag <= '0;
      rd_tag <= '0;
    end else begin
      if (push) wr_tag <= wr_tag + TW'(1);
      if (pop)  rd_tag <= rd_tag + TW'(1);
    end
  end

  assign head_addr = addr_mem[rd_tag[PW-1:0]];
  assign head_data = data_mem[rd_tag[PW-1:0]];
  assign empty     = (wr_tag == rd_tag);
  assign full      = (wr_tag[PW] != rd_tag[PW]) && (wr_tag[PW-1:0] == rd_tag[PW-1:0]);

  // R3: no write enters a full buffer and occupancy never exceeds DEPTH
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_occupancy_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_tag - rd_tag) <= TW'(DEPTH));
  p_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/wo_order_sel.sv
module wo_order_sel #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          weak_mode,
  input  logic          cpu_lock,
  input  logic          snp_valid,
  input  logic          fifo_empty,
  input  logic          path_idle,
  input  logic          out_free,
  input  logic [TW-1:0] wr_tag,
  input  logic [TW-1:0] rd_tag,
  output logic          take_snoop,
  output logic          take_fifo
);
  logic          stamped_q;
  logic [TW-1:0] stamp_q;
  logic [TW-1:0] eff_stamp;
  logic          lock_hold_q;
  logic          strong_eff;
  logic          snp_ok;

  // Lock forces strong ordering and keeps it until the write path is fully idle.
  assign strong_eff = ~weak_mode | cpu_lock | lock_hold_q;
  // A newly arrived snoop takes the current tail tag as its stamp.
  assign eff_stamp  = stamped_q ? stamp_q : wr_tag;
  assign snp_ok     = snp_valid && (!strong_eff || (rd_tag == eff_stamp));
  assign take_snoop = out_free && snp_ok;
  assign take_fifo  = out_free && !snp_ok && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      stamped_q <= 1'b0;
      stamp_q   <= '0;
    end else if (take_snoop || !snp_valid) begin
      stamped_q <= 1'b0;
    end else if (!stamped_q) begin
      stamped_q <= 1'b1;
      stamp_q   <= wr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            lock_hold_q <= 1'b0;
    else if (cpu_lock)  lock_hold_q <= 1'b1;
    else if (path_idle) lock_hold_q <= 1'b0;
  end

  // R4: a stamped snoop never passes a buffered entry older than its stamp
  p_strong_order_r4: assert property (@(posedge clk) disable iff (rst)
    (strong_eff && stamped_q && (rd_tag != stamp_q)) |-> !take_snoop);
  // R5: in weak ordering, a snoop is never held back from a free port
  p_weak_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (!strong_eff && snp_valid && out_free) |-> take_snoop);
  // R8: while locked, the FIFO head is never skipped by an unstamped snoop
  p_lock_order_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_lock && snp_valid && !fifo_empty && (rd_tag != eff_stamp)) |-> !take_snoop);
endmodule

// File: rtl/wr_order_arb.sv
module wr_order_arb #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int TW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_order_n,
  input  logic          cpu_lock,
  input  logic          cpu_wr_valid,
  output logic          cpu_wr_ready,
  input  logic [AW-1:0] cpu_wr_addr,
  input  logic [DW-1:0] cpu_wr_data,
  input  logic          snp_valid,
  output logic          snp_ready,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          mem_src,
  output logic          wb_empty
);
  import wo_pkg::*;

  logic          weak_mode;
  logic          full, empty, push, pop;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [TW-1:0] wr_tag, rd_tag, wr_nx, rd_nx;
  logic          take_snoop, take_fifo, load, out_free, valid_nx;
  logic          mem_valid_q, wbe_q;
  logic [AW-1:0] mem_addr_q;
  logic [DW-1:0] mem_data_q;
  wo_src_e       mem_src_q;

  wo_mode_latch i_mode (
    .clk(clk), .rst(rst), .cfg_order_n(cfg_order_n), .weak_o(weak_mode)
  );

  assign push = cpu_wr_valid && !full;

  wo_post_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(cpu_wr_addr), .push_data(cpu_wr_data),
    .pop(pop), .head_addr(head_addr), .head_data(head_data),
    .full(full), .empty(empty), .wr_tag(wr_tag), .rd_tag(rd_tag)
  );

  assign out_free = !mem_valid_q || mem_ready;

  wo_order_sel #(.TW(TW)) i_sel (
    .clk(clk), .rst(rst), .weak_mode(weak_mode), .cpu_lock(cpu_lock),
    .snp_valid(snp_valid), .fifo_empty(empty),
    .path_idle(empty && !mem_valid_q), .out_free(out_free),
    .wr_tag(wr_tag), .rd_tag(rd_tag),
    .take_snoop(take_snoop), .take_fifo(take_fifo)
  );

  assign pop  = take_fifo;
  assign load = take_snoop | take_fifo;

  // Single registered bus stage: holds the write in flight until accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid_q <= 1'b0;
      mem_addr_q  <= '0;
      mem_data_q  <= '0;
      mem_src_q   <= SRC_CPU;
    end else if (load) begin
      mem_valid_q <= 1'b1;
      mem_addr_q  <= take_snoop ? snp_addr : head_addr;
      mem_data_q  <= take_snoop ? snp_data : head_data;
      mem_src_q   <= take_snoop ? SRC_SNOOP : SRC_CPU;
    end else if (mem_ready) begin
      mem_valid_q <= 1'b0;
    end
  end

  // Buffer-empty flag computed from next state, so it tracks the registers exactly.
  assign wr_nx    = wr_tag + TW'(push);
  assign rd_nx    = rd_tag + TW'(pop);
  assign valid_nx = load | (mem_valid_q & ~mem_ready);

  always_ff @(posedge clk) begin
    if (rst) wbe_q <= 1'b0;
    else     wbe_q <= weak_mode | ((wr_nx == rd_nx) && !valid_nx);
  end

  assign cpu_wr_ready = !full;
  assign snp_ready    = take_snoop;
  assign mem_valid    = mem_valid_q;
  assign mem_addr     = mem_addr_q;
  assign mem_data     = mem_data_q;
  assign mem_src      = mem_src_q;
  assign wb_empty     = wbe_q;

  // R10: a stalled bus write is frozen
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_src)));
  // R6: weak mode keeps the flag active
  p_wbe_weak_r6: assert property (@(posedge clk) disable iff (rst)
    weak_mode |=> wb_empty);
  // R7: in strong mode the flag is never active with data pending
  p_wbe_strong_r7: assert property (@(posedge clk) disable iff (rst)
    (!weak_mode && wb_empty) |-> (empty && !mem_valid));
endmodule

// File: tb/test_wr_order_arb.sv
module test_wr_order_arb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst, cfg_order_n, cpu_lock;
  logic          cpu_wr_valid, cpu_wr_ready;
  logic [AW-1:0] cpu_wr_addr;
  logic [DW-1:0] cpu_wr_data;
  logic          snp_valid, snp_ready;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_data;
  logic          mem_valid, mem_ready, mem_src, wb_empty;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int log_n = 0;
  int log_addr [16];
  bit log_src [16];

  wr_order_arb #(.AW(AW), .DW(DW), .DEPTH(4)) i_wr_order_arb (
    .clk(clk), .rst(rst), .cfg_order_n(cfg_order_n), .cpu_lock(cpu_lock),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .snp_valid(snp_valid), .snp_ready(snp_ready),
    .snp_addr(snp_addr), .snp_data(snp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_src(mem_src), .wb_empty(wb_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Record every bus handshake that will complete at the next rising edge.
  always @(negedge clk) begin
    if (!rst && mem_valid && mem_ready && log_n < 16) begin
      log_addr[log_n] = int'(mem_addr);
      log_src[log_n]  = mem_src;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit strap);
    rst = 1'b1; cfg_order_n = strap; cpu_lock = 1'b0;
    cpu_wr_valid = 1'b0; snp_valid = 1'b0; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_valid, "R9", "mem_valid in reset", int'(mem_valid), 0);
    check(!wb_empty, "R9", "wb_empty in reset", int'(wb_empty), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    log_n = 0;
  endtask

  task automatic push(input int a);
    cpu_wr_valid = 1'b1;
    cpu_wr_addr  = AW'(a);
    cpu_wr_data  = DW'(a * 3);
    @(posedge clk); #1;
    cpu_wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic snoop(input int a);
    snp_valid = 1'b1;
    snp_addr  = AW'(a);
    snp_data  = DW'(a + 7);
  endtask

  task automatic drain(input int n);
    bit take;
    mem_ready = 1'b1;
    for (int k = 0; k < 60 && log_n < n; k++) begin
      @(negedge clk);
      take = snp_valid && snp_ready;
      @(posedge clk); #1;
      if (take) snp_valid = 1'b0;
    end
  endtask

  task automatic chk_log(input string req, input int idx, input int ea, input bit es);
    check(log_addr[idx] == ea, req, $sformatf("bus write %0d address", idx), log_addr[idx], ea);
    check(log_src[idx] == es, req, $sformatf("bus write %0d source", idx), int'(log_src[idx]), int'(es));
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    push(1); push(2);
    do_reset(1'b1);
    mem_ready = 1'b1;
    idle(6);
    check(log_n == 0, "R9", "writes after mid-stream reset", log_n, 0);
    @(negedge clk);
    check(wb_empty, "R7", "wb_empty idle strong", int'(wb_empty), 1);
    check(cpu_wr_ready, "R9", "ready after reset", int'(cpu_wr_ready), 1);
  endtask

  task automatic t_strong;
    do_reset(1'b1);
    push(1); push(2); push(3);
    @(negedge clk);
    check(!wb_empty, "R7", "wb_empty with pending", int'(wb_empty), 0);
    check(mem_valid && mem_addr == 1, "R10", "stalled head", int'(mem_addr), 1);
    cfg_order_n = 1'b0;  // pin reused after reset: must not switch the mode
    @(posedge clk); #1;
    snoop(128);
    idle(3);
    @(negedge clk);
    check(mem_addr == 1, "R10", "address held under stall", int'(mem_addr), 1);
    check(!wb_empty, "R2", "strong mode kept after pin change", int'(wb_empty), 0);
    @(posedge clk); #1;
    drain(4);
    check(log_n == 4, "R4", "bus write count", log_n, 4);
    chk_log("R4", 0, 1, 1'b0);
    chk_log("R4", 1, 2, 1'b0);
    chk_log("R4", 2, 3, 1'b0);
    chk_log("R4", 3, 128, 1'b1);
    idle(2);
    @(negedge clk);
    check(wb_empty, "R7", "wb_empty after drain", int'(wb_empty), 1);
    @(posedge clk); #1;
  endtask

  task automatic t_full;
    do_reset(1'b1);
    for (int i = 1; i <= 5; i++) push(i);
    @(negedge clk);
    check(!cpu_wr_ready, "R3", "ready when full", int'(cpu_wr_ready), 0);
    @(posedge clk); #1;
    drain(5);
    check(log_n == 5, "R11", "bus write count", log_n, 5);
    for (int i = 0; i < 5; i++) chk_log("R11", i, i + 1, 1'b0);
  endtask

  task automatic t_weak;
    do_reset(1'b0);
    idle(2);
    @(negedge clk);
    check(wb_empty, "R6", "wb_empty idle weak", int'(wb_empty), 1);
    @(posedge clk); #1;
    push(1); push(2); push(3);
    cfg_order_n = 1'b1;
    idle(1);
    @(negedge clk);
    check(wb_empty, "R6", "wb_empty with pending weak", int'(wb_empty), 1);
    check(wb_empty, "R2", "weak mode kept after pin change", int'(wb_empty), 1);
    @(posedge clk); #1;
    snoop(128);
    drain(4);
    check(log_n == 4, "R5", "bus write count", log_n, 4);
    chk_log("R5", 0, 1, 1'b0);
    chk_log("R5", 1, 128, 1'b1);
    chk_log("R5", 2, 2, 1'b0);
    chk_log("R5", 3, 3, 1'b0);
  endtask

  task automatic t_lock;
    do_reset(1'b0);
    cpu_lock = 1'b1;
    push(1); push(2); push(3);
    snoop(128);
    drain(4);
    cpu_lock = 1'b0;
    check(log_n == 4, "R8", "locked write count", log_n, 4);
    chk_log("R8", 0, 1, 1'b0);
    chk_log("R8", 3, 128, 1'b1);
    idle(2);
    // Lock released early: ordering stays strong until the path is idle.
    mem_ready = 1'b0; log_n = 0;
    cpu_lock = 1'b1;
    push(1);
    cpu_lock = 1'b0;
    push(2); push(3);
    snoop(129);
    drain(4);
    check(log_n == 4, "R8", "post-lock write count", log_n, 4);
    chk_log("R8", 1, 2, 1'b0);
    chk_log("R8", 2, 3, 1'b0);
    chk_log("R8", 3, 129, 1'b1);
    idle(2);
    // Path idle and lock low: weak ordering returns.
    mem_ready = 1'b0; log_n = 0;
    push(1); push(2); push(3);
    snoop(130);
    drain(4);
    chk_log("R8", 1, 130, 1'b1);
    chk_log("R8", 2, 2, 1'b0);
  endtask

  initial begin
    rst = 1'b1; cfg_order_n = 1'b1; cpu_lock = 1'b0;
    cpu_wr_valid = 1'b0; cpu_wr_addr = '0; cpu_wr_data = '0;
    snp_valid = 1'b0; snp_addr = '0; snp_data = '0; mem_ready = 1'b0;
    #1;
    t_reset();
    t_strong();   // R1 strong strap
    t_full();
    t_weak();     // R1 weak strap
    t_lock();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule